// File: doc/BRIEF.md
# Hardware Store Handshake Controller

This block decides when a nonvolatile store may run in response to a shared, open-drain request line that other devices can also pull low. It keeps a flag telling whether any memory write has completed since the last store or recall. The store goes ahead only when that flag is set. When the synchronized line is seen low and the flag is set, the block pulls the line low itself at once. It then grants a grace period in which reads still run and an access already under way may finish. After the grace period it holds the line for a check window and then fires a one-cycle start pulse to the store engine.

The pull-down stays on until the engine reports completion. After that, every memory access stays blocked until the shared line is seen high again. If some external driver keeps the line high through the check window, the attempt is dropped and the dirty flag is kept. A store begun by other means (an alternate start input) also drives the line for its whole length. A request that arrives while a recall runs waits until the recall is over and is then judged again.

Top module: `hs_store_ctl`

## Requirements
- R1: With the synchronized line low, the dirty flag set and no recall running, the block leaves idle and starts the grace period. With the dirty flag clear, a low line gives no pull-down and no start pulse.
- R2: The grace period lasts GRACE_CYC cycles. During it `rd_allow_o` is 1 and `wr_allow_o` is 0.
- R3: `wr_allow_o` is 0 whenever the synchronized line is low. It returns to 1 only when the block is idle and the line is seen high.
- R4: `line_pull_o` is 1 from the first grace cycle to the end of the store. It is also 1 for a store begun by `alt_store_i`. It drops on the edge that samples `store_done_i`.
- R5: After a store completes, `rd_allow_o` and `wr_allow_o` stay 0 until the synchronized line is high. The block is idle again SYNC_STAGES+1 edges after the line rises.
- R6: The check window lasts HOLD_CYC cycles after the grace period, with reads blocked. If the synchronized line is high at its end, the attempt is dropped: the block returns to idle, gives no start pulse and keeps the dirty flag.
- R7: `line_pull_o` rises exactly SYNC_STAGES+1 clock edges after the request line falls, provided the dirty flag is set and no recall runs.
- R8: The dirty flag is set by `wr_seen_i`. It is cleared by `recall_done_i` or by `store_done_i` during a store, and a clear wins over a set.
- R9: `store_start_o` is a single-cycle pulse in the first store cycle. It comes only after a line-requested check window that passes, never for an alternate start.
- R10: While `recall_busy_i` is 1, a low request line starts nothing. The request is judged once the recall ends.
- R11: During and right after reset, `line_pull_o`=0, `rd_allow_o`=1, `wr_allow_o`=1 and `store_start_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_line_i | input | 1 | Level sensed on the shared open-drain line |
| wr_seen_i | input | 1 | Pulse: a memory write has completed |
| store_done_i | input | 1 | Pulse: the store engine has finished |
| recall_busy_i | input | 1 | A recall is running |
| recall_done_i | input | 1 | Pulse: a recall has finished |
| alt_store_i | input | 1 | Pulse: a store was begun by other means |
| line_pull_o | output | 1 | Enable for the pull-down on the shared line |
| rd_allow_o | output | 1 | Memory reads may run |
| wr_allow_o | output | 1 | New memory writes may begin |
| store_start_o | output | 1 | One-cycle pulse that launches the store engine |

## Verification
The request line passes through SYNC_STAGES flops and then the state register. So the pull-down and the write block are due SYNC_STAGES+1 edges after the line moves, and the bench samples at exactly that edge and one edge earlier. The grace period ends GRACE_CYC edges after the pull-down rises, and the start pulse comes HOLD_CYC edges after that, both counted edge by edge from the negative edge where the stimulus is driven. Completion and alternate starts act on the very next edge, so they are checked one edge later. All sampling is done at negative edges, half a period away from the edges that update the design.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GRACE = 3'd1,
    ST_HOLD  = 3'd2,
    ST_STORE = 3'd3,
    ST_LOCK  = 3'd4
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RST_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_dirty.sv
module hs_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q, dirty_d, dirty_en;

  always_comb begin
    dirty_en = set_i | clr_i;
    dirty_d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dirty_q <= 1'b0;
    else if (dirty_en) dirty_q <= dirty_d;
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hs_store_ctl.sv
module hs_store_ctl #(
  parameter int SYNC_STAGES = 2,
  parameter int GRACE_CYC   = 250,
  parameter int HOLD_CYC    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_line_i,
  input  logic wr_seen_i,
  input  logic store_done_i,
  input  logic recall_busy_i,
  input  logic recall_done_i,
  input  logic alt_store_i,
  output logic line_pull_o,
  output logic rd_allow_o,
  output logic wr_allow_o,
  output logic store_start_o
);
  import hs_pkg::*;

  localparam int MAXW = (GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC;
  localparam int TW   = $clog2(MAXW + 1);
  localparam logic [TW-1:0] GRACE_LD = TW'(GRACE_CYC - 1);
  localparam logic [TW-1:0] HOLD_LD  = TW'(HOLD_CYC - 1);

  hs_state_e state_q, state_d;
  logic      line_s, dirty, tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;
  logic      start_q, start_d;
  logic      dirty_clr;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_line_i), .q_o(line_s)
  );

  assign dirty_clr = recall_done_i | ((state_q == ST_STORE) & store_done_i);

  hs_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .set_i(wr_seen_i), .clr_i(dirty_clr), .dirty_o(dirty)
  );

  hs_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = GRACE_LD;
    start_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (alt_store_i) begin
          state_d = ST_STORE;
        end else if (!line_s && dirty && !recall_busy_i) begin
          state_d  = ST_GRACE;
          tmr_load = 1'b1;
          tmr_val  = GRACE_LD;
        end
      end
      ST_GRACE: begin
        if (tmr_zero) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          if (line_s) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_STORE;
            start_d = 1'b1;
          end
        end
      end
      ST_STORE: begin
        if (store_done_i) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (line_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign line_pull_o   = (state_q == ST_GRACE) | (state_q == ST_HOLD) | (state_q == ST_STORE);
  assign rd_allow_o    = (state_q == ST_IDLE) | (state_q == ST_GRACE);
  assign wr_allow_o    = (state_q == ST_IDLE) & line_s;
  assign store_start_o = start_q;
endmodule

// File: rtl/hs_store_ctl_chk.sv
module hs_store_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_line_i,
  input logic line_pull_o,
  input logic rd_allow_o,
  input logic wr_allow_o,
  input logic store_start_o
);
  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |=> !store_start_o);

  // R4
  start_pulled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |-> line_pull_o);

  // R6
  start_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start_o |-> $past(line_pull_o));

  // R3
  low_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_line_i) && !$past(req_line_i, 2)) |-> !wr_allow_o);

  // R2
  pull_rise_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pull_o) |-> !wr_allow_o);

  // R5
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_pull_o && !rd_allow_o && !$past(req_line_i)) |=> (!rd_allow_o && !wr_allow_o));
endmodule

bind hs_store_ctl hs_store_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_line_i(req_line_i), .line_pull_o(line_pull_o),
  .rd_allow_o(rd_allow_o), .wr_allow_o(wr_allow_o), .store_start_o(store_start_o)
);

// File: tb/sim_hs_store_ctl.sv
module sim_hs_store_ctl;
  localparam int SYNC = 2;
  localparam int GR   = 6;
  localparam int HD   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_low = 1'b0, force_hi = 1'b0;
  logic wr_seen = 1'b0, done = 1'b0, rbusy = 1'b0, rdone = 1'b0, alt = 1'b0;
  logic req_line, pull, rd_ok, wr_ok, start;
  int   n_chk = 0, n_fail = 0, n_start = 0;

  always #2 clk = ~clk;

  assign req_line = force_hi | ~(pull | ext_low);

  hs_store_ctl #(.SYNC_STAGES(SYNC), .GRACE_CYC(GR), .HOLD_CYC(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_line_i(req_line), .wr_seen_i(wr_seen),
    .store_done_i(done), .recall_busy_i(rbusy), .recall_done_i(rdone),
    .alt_store_i(alt), .line_pull_o(pull), .rd_allow_o(rd_ok),
    .wr_allow_o(wr_ok), .store_start_o(start)
  );

  always @(negedge clk) if (rst_n && start) n_start++;

  typedef struct packed {
    logic       lo;
    logic       wp;
    logic       rdp;
    logic       rb;
    logic [3:0] wt;
    logic [2:0] ex;
  } row_t;

  localparam row_t TBL [0:10] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 3'b011},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 3'b010},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 3'b011},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd2, 3'b011},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 3'b011},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd6, 3'b010},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 3'b011},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 3'b011},
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd6, 3'b010},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 3'b011},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 3'b011}
  };

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pull, rd_ok, wr_ok, start};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {pull,rd,wr,start} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_seen = 1'b1; edges(1); wr_seen = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int s0;
    edges(2);
    chk("R11 in reset", 4'b0110);
    rst_n = 1'b1;
    edges(1);
    chk("R11 after reset", 4'b0110);

    // R1 R3 R8 R10: vector table
    for (int i = 0; i < 11; i++) begin
      ext_low = TBL[i].lo; rbusy = TBL[i].rb;
      wr_seen = TBL[i].wp; rdone = TBL[i].rdp;
      edges(1);
      wr_seen = 1'b0; rdone = 1'b0;
      edges(int'(TBL[i].wt) - 1);
      chk($sformatf("R1/R3/R8/R10 row %0d", i), {TBL[i].ex, 1'b0});
    end

    // Full store: R7 R2 R6 R9 R4 R5 R8
    pulse_wr();
    s0 = n_start;
    ext_low = 1'b1;
    edges(2);
    chk("R7 not yet pulled", 4'b0100);
    edges(1);
    chk("R7 pull on time", 4'b1100);
    ext_low = 1'b0;
    edges(3);
    chk("R2 grace reads on", 4'b1100);
    edges(3);
    chk("R6 hold reads off", 4'b1000);
    edges(7);
    chk("R9 no early start", 4'b1000);
    edges(1);
    chk("R9 start pulse", 4'b1001);
    edges(1);
    chk("R9 pulse ends R4 pulled", 4'b1000);
    ext_low = 1'b1;
    edges(20);
    chk("R4 held during store", 4'b1000);
    done = 1'b1; edges(1); done = 1'b0;
    chk("R4 released R5 locked", 4'b0000);
    edges(5);
    chk("R5 still locked", 4'b0000);
    ext_low = 1'b0;
    edges(2);
    chk("R5 lock until sync", 4'b0000);
    edges(1);
    chk("R5 idle again", 4'b0110);
    if (n_start != s0 + 1) begin
      n_fail++; $display("FAIL R9: starts actual %0d expected %0d", n_start - s0, 1);
    end
    n_chk++;
    ext_low = 1'b1;
    edges(6);
    chk("R8 cleared by store", 4'b0100);
    ext_low = 1'b0;
    edges(4);

    // Abort: R6
    pulse_wr();
    s0 = n_start;
    ext_low = 1'b1;
    edges(3);
    chk("R7 pull again", 4'b1100);
    ext_low = 1'b0; force_hi = 1'b1;
    edges(13);
    chk("R6 still holding", 4'b1000);
    edges(1);
    chk("R6 abort to idle", 4'b0110);
    n_chk++;
    if (n_start != s0) begin
      n_fail++; $display("FAIL R6: starts actual %0d expected %0d", n_start - s0, 0);
    end
    force_hi = 1'b0;
    ext_low = 1'b1;
    edges(3);
    chk("R6 dirty kept", 4'b1100);
    ext_low = 1'b0;
    edges(14);
    chk("R9 start after retry", 4'b1001);
    edges(2);
    done = 1'b1; edges(1); done = 1'b0;
    edges(3);
    chk("R5 back to idle", 4'b0110);

    // Alternate start: R4 R9
    s0 = n_start;
    alt = 1'b1; edges(1); alt = 1'b0;
    chk("R4 alt store pulls", 4'b1000);
    edges(5);
    chk("R4 alt store held", 4'b1000);
    done = 1'b1; edges(1); done = 1'b0;
    chk("R4 alt released", 4'b0000);
    edges(3);
    chk("R5 alt idle", 4'b0110);
    n_chk++;
    if (n_start != s0) begin
      n_fail++; $display("FAIL R9: alt starts actual %0d expected %0d", n_start - s0, 0);
    end

    finish_run();
  end
endmodule